// File: doc/BRIEF.md
# Deficiency-Based Combinational Squarer

This block squares a 4-bit unsigned operand into an 8-bit result with no partial-product array. It sorts the operand into one of three ranges around the value 8. Operands below 8 go straight into a small gate-level 3-bit squaring core. Operands above 8 are first turned into their distance from 16, which is the 4-bit two's complement. That distance is squared by the same core, and two ripple-carry additions of the operand shifted left by four restore the true square. This works because 32A + (16 - A)^2 = A^2 + 256, and the carry out of bit 7 is dropped. The operand 8 itself is a left shift by three.

The block is purely combinational. A second copy of the 3-bit core is brought out on its own ports so the core can be tested apart from the full path.

Top module: `dfc_squarer`

## Requirements
- R1: When a_i[3] is 0, sq_o equals the zero-extended 6-bit core square of a_i[2:0], so sq_o is below 64.
- R2: The 3-bit core maps input x in 0..7 to x*x: 0, 1, 4, 9, 16, 25, 36, 49, and never exceeds 49.
- R3: Bit 1 of the core output is always 0, for every core input.
- R4: When a_i is above 8, the deficiency 16 - a_i is formed as invert-plus-one and always falls in 1..7, with bit 3 clear.
- R5: When a_i is above 8, sq_o is the low 8 bits of (deficiency squared) + 16*a_i + 16*a_i, with carries out of bit 7 discarded and not saturated. This gives a_i*a_i, which is at least 81.
- R6: When a_i equals 8 (binary 1000), sq_o equals a_i shifted left by three, which is 64.
- R7: Exactly one path is active. a_i[3]=0 selects the small path. a_i[3]=1 with any of a_i[2:0] set selects the large path. Exactly 1000 selects the shift path.
- R8: For every a_i in 0..15, sq_o equals a_i*a_i. This includes 3 giving 9, 5 giving 25 and 15 giving 225. Bit 1 of sq_o is always 0.
- R9: core_o equals core_i*core_i and depends only on core_i. Changing a_i leaves core_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Unsigned operand to square |
| sq_o | output | 8 | Square of a_i |
| core_i | input | 3 | Operand for the standalone 3-bit core copy |
| core_o | output | 6 | Square of core_i from the standalone core copy |

## Verification
The embedded assertions check several properties at every settle of the logic:
- the path decode is one-hot, and a clear bit 3 always selects the small path;
- the deficiency stays in 1..7 whenever the large path is active;
- the core output never sets bit 1 and never exceeds 49;
- sq_o falls in the range its path allows, and equals 64 on the shift path.

These range checks cannot catch a wrong value inside a legal range, such as a dropped carry that still lands above 80. Exact squares therefore come only from the bench. It sweeps all sixteen operands and all eight core inputs, and runs randomized pairs that move a_i while core_i is held, to show the core ports are independent.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  localparam int unsigned IN_W   = 4;
  localparam int unsigned OUT_W  = 2 * IN_W;
  localparam int unsigned CORE_W = IN_W - 1;
  localparam int unsigned CORE_O = 2 * CORE_W;
  localparam int unsigned MID_SH = IN_W - 1;

  typedef enum logic [2:0] {
    PATH_LO  = 3'b001,
    PATH_HI  = 3'b010,
    PATH_MID = 3'b100
  } path_e;
endpackage

// File: rtl/sqr_core3.sv
module sqr_core3
  import sqr_pkg::*;
(
  input  logic [CORE_W-1:0] x_i,
  output logic [CORE_O-1:0] s_o
);
  logic x0, x1, x2;
  assign x0 = x_i[0];
  assign x1 = x_i[1];
  assign x2 = x_i[2];

  // gate-level square of a 3-bit value
  assign s_o[0] = x0;
  assign s_o[1] = 1'b0;
  assign s_o[2] = x1 & ~x0;
  assign s_o[3] = x0 & (x1 ^ x2);
  assign s_o[4] = x2 & (~x1 | x0);
  assign s_o[5] = x2 & x1;

  always_comb begin
    p_core_bit1_r3: assert (s_o[1] == 1'b0)
      else $error("core bit1 set for %0d", x_i);
    p_core_max_r2: assert (s_o <= 6'd49)
      else $error("core out %0d above 49", s_o);
  end
endmodule

// File: rtl/sqr_rca.sv
module sqr_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] c;
  assign c[0] = cin_i;

  // carry out of the top bit is intentionally not formed (modulo 2^W)
  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign sum_o[i] = p ^ c[i];
    if (i < W - 1) begin : g_c
      assign c[i+1] = (a_i[i] & b_i[i]) | (c[i] & p);
    end
  end
endmodule

// File: rtl/sqr_path_dec.sv
module sqr_path_dec
  import sqr_pkg::*;
(
  input  logic [IN_W-1:0] a_i,
  output path_e           path_o
);
  logic lo_any;
  assign lo_any = |a_i[IN_W-2:0];

  always_comb begin
    if (!a_i[IN_W-1])  path_o = PATH_LO;
    else if (lo_any)   path_o = PATH_HI;
    else               path_o = PATH_MID;
  end

  always_comb begin
    p_dec_onehot_r7: assert ($onehot(path_o))
      else $error("path select not one-hot: %b", path_o);
    p_dec_lo_r7: assert (a_i[IN_W-1] || path_o == PATH_LO)
      else $error("bit3 clear but path %b", path_o);
  end
endmodule

// File: rtl/dfc_squarer.sv
module dfc_squarer
  import sqr_pkg::*;
#(
  parameter bit EXPOSE_CORE = 1'b1
) (
  input  logic [IN_W-1:0]   a_i,
  output logic [OUT_W-1:0]  sq_o,
  input  logic [CORE_W-1:0] core_i,
  output logic [CORE_O-1:0] core_o
);
  path_e               path;
  logic [IN_W-1:0]     def;
  logic [CORE_W-1:0]   core_sel;
  logic [CORE_O-1:0]   m;
  logic [OUT_W-1:0]    m_ext, shl4, h_sum, z_sum, mid_val;

  sqr_path_dec u_dec (.a_i(a_i), .path_o(path));

  // deficiency = invert + 1
  sqr_rca #(.W(IN_W)) u_neg (
    .a_i(~a_i), .b_i('0), .cin_i(1'b1), .sum_o(def)
  );

  assign core_sel = (path == PATH_HI) ? def[CORE_W-1:0] : a_i[CORE_W-1:0];

  sqr_core3 u_core (.x_i(core_sel), .s_o(m));

  assign m_ext   = {{(OUT_W-CORE_O){1'b0}}, m};
  assign shl4    = {a_i, {IN_W{1'b0}}};
  assign mid_val = {{(OUT_W-IN_W-MID_SH){1'b0}}, a_i, {MID_SH{1'b0}}};

  sqr_rca #(.W(OUT_W)) u_add_h (
    .a_i(m_ext), .b_i(shl4), .cin_i(1'b0), .sum_o(h_sum)
  );
  sqr_rca #(.W(OUT_W)) u_add_z (
    .a_i(h_sum), .b_i(shl4), .cin_i(1'b0), .sum_o(z_sum)
  );

  always_comb begin
    unique case (path)
      PATH_HI:  sq_o = z_sum;
      PATH_MID: sq_o = mid_val;
      default:  sq_o = m_ext;
    endcase
  end

  if (EXPOSE_CORE) begin : g_core_tap
    sqr_core3 u_core_tap (.x_i(core_i), .s_o(core_o));
  end else begin : g_core_off
    assign core_o = '0;
  end

  always_comb begin
    if (path == PATH_HI) begin
      p_def_range_r4: assert (!def[IN_W-1] && def != '0)
        else $error("deficiency %0d out of range", def);
      p_hi_range_r5: assert (sq_o >= 8'd81)
        else $error("large path result %0d below 81", sq_o);
    end
    if (path == PATH_LO) begin
      p_lo_range_r1: assert (sq_o < 8'd64)
        else $error("small path result %0d not below 64", sq_o);
    end
    if (path == PATH_MID) begin
      p_mid_val_r6: assert (sq_o == 8'd64)
        else $error("shift path result %0d", sq_o);
    end
    p_sq_bit1_r8: assert (sq_o[1] == 1'b0)
      else $error("square bit1 set: %0d", sq_o);
  end
endmodule

// File: tb/sim_dfc_squarer.sv
module sim_dfc_squarer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a;
  logic [7:0] sq;
  logic [2:0] ci;
  logic [5:0] co;
  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dfc_squarer u0 (.a_i(a), .sq_o(sq), .core_i(ci), .core_o(co));

  function automatic logic [7:0] exp_sq(input logic [3:0] x);
    return 8'(x * x);
  endfunction

  function automatic logic [5:0] exp_core(input logic [2:0] x);
    return 6'(x * x);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] av, input logic [2:0] cv);
    @(posedge clk);
    a  <= av;
    ci <= cv;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    void'($urandom(32'd1234));
    a  = '0;
    ci = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // initial state: zero operand gives zero
    check("R1 reset-state sq", sq, 0);
    check("R9 reset-state core", co, 0);

    // R2 R3: core alone, all entries
    for (int x = 0; x < 8; x++) begin
      apply(4'd0, 3'(x));
      check("R2 core table", co, exp_core(3'(x)));
      check("R3 core bit1", co[1], 0);
    end

    // R8 sweep all operands
    for (int x = 0; x < 16; x++) begin
      apply(4'(x), 3'd0);
      check("R8 sweep", sq, exp_sq(4'(x)));
      check("R8 bit1", sq[1], 0);
      if (x < 8)  check("R1 below 64", int'(sq < 8'd64), 1);
      if (x > 8)  check("R5 at least 81", int'(sq >= 8'd81), 1);
    end

    // directed corners
    apply(4'd3, 3'd0);  check("R8 3->9", sq, 9);
    apply(4'd5, 3'd0);  check("R8 5->25", sq, 25);
    apply(4'd15, 3'd0); check("R5 15->225 carry drop", sq, 225);
    apply(4'd9, 3'd0);  check("R4 R5 deficiency 7", sq, 81);
    apply(4'd8, 3'd0);  check("R6 R7 shift path", sq, 64);
    apply(4'd7, 3'd0);  check("R7 R1 top of small path", sq, 49);
    apply(4'd12, 3'd0); check("R4 deficiency 4", sq, 144);

    // R9 core independent of a_i
    apply(4'd0, 3'd6);
    held = co;
    check("R9 core value", co, 36);
    for (int x = 1; x < 16; x++) begin
      apply(4'(x), 3'd6);
      check("R9 core unaffected", co, held);
    end

    // random mix
    for (int k = 0; k < 200; k++) begin
      logic [3:0] ra;
      logic [2:0] rc;
      ra = 4'($urandom);
      rc = 3'($urandom);
      apply(ra, rc);
      check("R8 random sq", sq, exp_sq(ra));
      check("R2 random core", co, exp_core(rc));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule